// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether an I2C transfer is meant for the local slave. A bit-level shifter hands it whole address bytes with a one-cycle valid strobe, together with one-cycle strobes for START, repeated START and STOP. A mode input selects 7-bit or 10-bit addressing. In 7-bit mode a single byte is matched. In 10-bit mode the block walks through the two-byte write address. It also handles the read turnaround, where the master issues a repeated START and resends only the first byte with the read bit set.

For every address byte that matches at its stage, the block raises a one-cycle acknowledge request. When the whole address has matched it raises a match flag and reports the transfer direction. Both outputs hold through the data phase until the next START, repeated START or STOP. A byte that fails to match makes the block deaf to the bus until the next START or repeated START. Bytes that arrive after a complete match are data and are left alone.

Top module: `i2c_addr_filter`

## Requirements
- R1: `ten_bit_i` = 0 selects single-byte (7-bit) matching. `ten_bit_i` = 1 selects the multi-byte (10-bit) sequence.
- R2: In 7-bit mode, a first byte after a START matches when bits [7:1] equal `own_hi_i`. On a match, `ack_req_o` pulses and `match_o` rises in the cycle after the byte strobe. `dir_rd_o` then equals byte bit 0 (1 = read).
- R3: In 7-bit mode, `rw_cmp_i` has no influence on the match.
- R4: In 10-bit mode, a first byte after a START is accepted only if bits [7:1] equal `own_hi_i` and bit 0 equals `rw_cmp_i`. An accepted first byte produces an `ack_req_o` pulse but leaves `match_o` low.
- R5: In 10-bit mode, the byte that follows an accepted first byte matches when it equals `own_lo_i`. It then pulses `ack_req_o` and raises `match_o`, and `dir_rd_o` carries bit 0 of the first byte.
- R6: After a repeated START, a 10-bit first byte whose bits [7:1] equal `own_hi_i` and whose bit 0 is 1 completes a read match on its own. This takes `ack_req_o` high, `match_o` high and `dir_rd_o` = 1, with no second byte. It applies only if a full two-byte address matched earlier with no START or STOP since.
- R7: A byte that fails at any address stage gives no `ack_req_o`. Every later byte is then ignored until a START or repeated START.
- R8: STOP clears `match_o` and `dir_rd_o` in the next cycle and forgets any earlier 10-bit address match. A byte strobed in the same cycle as STOP is ignored.
- R9: Once `match_o` is high, further bytes cause no `ack_req_o` and leave `match_o` and `dir_rd_o` unchanged.
- R10: START or repeated START clears `match_o` in the next cycle and arms first-byte matching. A byte strobed in the same cycle as the strobe is ignored.
- R11: After reset, all outputs are low and bytes are ignored until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ten_bit_i | input | 1 | Address format: 0 = 7-bit, 1 = 10-bit |
| own_hi_i | input | 7 | Slave address upper field / 7-bit address |
| rw_cmp_i | input | 1 | Compare value for bit 0 of a 10-bit first byte |
| own_lo_i | input | 8 | Second 10-bit address byte |
| start_i | input | 1 | START strobe |
| restart_i | input | 1 | Repeated START strobe |
| stop_i | input | 1 | STOP strobe |
| byte_vld_i | input | 1 | Address/data byte strobe |
| byte_i | input | 8 | Received byte, bit 0 last on the wire |
| match_o | output | 1 | Complete address matched |
| dir_rd_o | output | 1 | Transfer direction, 1 = slave transmits |
| ack_req_o | output | 1 | One-cycle request to acknowledge the byte |

## Verification
A byte strobe can land in the same cycle as a bus-condition strobe. Both a STOP and a START can coincide with a byte whose value would otherwise match. The bench drives each pairing in a single cycle. It judges the result by the absence of an acknowledge and by the state left behind. After STOP-plus-byte, a following matching byte must still be ignored. After START-plus-byte, a following matching byte must be accepted as the first address byte.

// File: rtl/i2c_af_pkg.sv
package i2c_af_pkg;

  typedef enum logic [1:0] {
    AF_IDLE   = 2'd0,
    AF_FIRST  = 2'd1,
    AF_SECOND = 2'd2,
    AF_DATA   = 2'd3
  } af_state_e;

endpackage

// File: rtl/i2c_af_cmp.sv
module i2c_af_cmp #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-2:0] own_hi_i,
  input  logic              rw_cmp_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  output logic              hit_hi_o,
  output logic              rw_eq_o,
  output logic              hit_lo_o,
  output logic              rw_o
);

  localparam int HI_W = BYTE_W - 1;

  function automatic logic [HI_W-1:0] hi_field(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1:1];
  endfunction

  function automatic logic rw_field(input logic [BYTE_W-1:0] b);
    return b[0];
  endfunction

  logic [BYTE_W-1:0] lo_eq;

  genvar gi;
  generate
    for (gi = 0; gi < BYTE_W; gi++) begin : g_lo_bit
      assign lo_eq[gi] = ~(byte_i[gi] ^ own_lo_i[gi]);
    end
  endgenerate

  assign hit_hi_o = (hi_field(byte_i) == own_hi_i);
  assign rw_o     = rw_field(byte_i);
  assign rw_eq_o  = (rw_field(byte_i) == rw_cmp_i);
  assign hit_lo_o = &lo_eq;

endmodule

// File: rtl/i2c_af_seq.sv
module i2c_af_seq
  import i2c_af_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ten_bit_i,
  input  logic start_i,
  input  logic restart_i,
  input  logic stop_i,
  input  logic byte_vld_i,
  input  logic hit_hi_i,
  input  logic rw_eq_i,
  input  logic hit_lo_i,
  input  logic rw_i,
  output logic acc7_o,
  output logic acc10a_o,
  output logic acc10b_o,
  output logic accrd_o,
  output logic clr_o
);

  af_state_e st_q, st_d;
  logic wr_ok_q;
  logic rd_arm_q;
  logic any_start;
  logic take;
  logic in_first;
  logic reject;

  assign any_start = start_i | restart_i;
  assign clr_o     = any_start | stop_i;
  assign take      = byte_vld_i & ~clr_o;
  assign in_first  = take & (st_q == AF_FIRST);

  assign acc7_o   = in_first & ~ten_bit_i & hit_hi_i;
  assign accrd_o  = in_first & ten_bit_i & rd_arm_q & hit_hi_i & rw_i;
  assign acc10a_o = in_first & ten_bit_i & ~accrd_o & hit_hi_i & rw_eq_i;
  assign acc10b_o = take & (st_q == AF_SECOND) & hit_lo_i;
  assign reject   = take & ((st_q == AF_FIRST) | (st_q == AF_SECOND))
                  & ~(acc7_o | accrd_o | acc10a_o | acc10b_o);

  always_comb begin
    st_d = st_q;
    if (any_start)                          st_d = AF_FIRST;
    else if (stop_i)                        st_d = AF_IDLE;
    else if (acc7_o | accrd_o | acc10b_o)   st_d = AF_DATA;
    else if (acc10a_o)                      st_d = AF_SECOND;
    else if (reject)                        st_d = AF_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= AF_IDLE;
      wr_ok_q  <= 1'b0;
      rd_arm_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (stop_i | start_i)  wr_ok_q <= 1'b0;
      else if (acc10b_o)     wr_ok_q <= 1'b1;
      if (stop_i | start_i)  rd_arm_q <= 1'b0;
      else if (restart_i)    rd_arm_q <= wr_ok_q;
      else if (in_first)     rd_arm_q <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_af_out.sv
module i2c_af_out (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic acc7_i,
  input  logic acc10a_i,
  input  logic acc10b_i,
  input  logic accrd_i,
  input  logic rw_i,
  output logic match_o,
  output logic dir_rd_o,
  output logic ack_req_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_o   <= 1'b0;
      dir_rd_o  <= 1'b0;
      ack_req_o <= 1'b0;
    end else begin
      ack_req_o <= acc7_i | acc10a_i | acc10b_i | accrd_i;
      if (clr_i) begin
        match_o  <= 1'b0;
        dir_rd_o <= 1'b0;
      end else begin
        if (acc7_i | acc10b_i | accrd_i) match_o <= 1'b1;
        if (acc7_i | acc10a_i)           dir_rd_o <= rw_i;
        else if (accrd_i)                dir_rd_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten_bit_i,
  input  logic [BYTE_W-2:0] own_hi_i,
  input  logic              rw_cmp_i,
  input  logic [BYTE_W-1:0] own_lo_i,
  input  logic              start_i,
  input  logic              restart_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              match_o,
  output logic              dir_rd_o,
  output logic              ack_req_o
);

  logic ev_hit_hi, ev_rw_eq, ev_hit_lo, ev_rw;
  logic ev_acc7, ev_acc10a, ev_acc10b, ev_accrd, ev_clr;

  i2c_af_cmp #(.BYTE_W(BYTE_W)) u_cmp (
    .byte_i   (byte_i),
    .own_hi_i (own_hi_i),
    .rw_cmp_i (rw_cmp_i),
    .own_lo_i (own_lo_i),
    .hit_hi_o (ev_hit_hi),
    .rw_eq_o  (ev_rw_eq),
    .hit_lo_o (ev_hit_lo),
    .rw_o     (ev_rw)
  );

  i2c_af_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ten_bit_i  (ten_bit_i),
    .start_i    (start_i),
    .restart_i  (restart_i),
    .stop_i     (stop_i),
    .byte_vld_i (byte_vld_i),
    .hit_hi_i   (ev_hit_hi),
    .rw_eq_i    (ev_rw_eq),
    .hit_lo_i   (ev_hit_lo),
    .rw_i       (ev_rw),
    .acc7_o     (ev_acc7),
    .acc10a_o   (ev_acc10a),
    .acc10b_o   (ev_acc10b),
    .accrd_o    (ev_accrd),
    .clr_o      (ev_clr)
  );

  i2c_af_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ev_clr),
    .acc7_i    (ev_acc7),
    .acc10a_i  (ev_acc10a),
    .acc10b_i  (ev_acc10b),
    .accrd_i   (ev_accrd),
    .rw_i      (ev_rw),
    .match_o   (match_o),
    .dir_rd_o  (dir_rd_o),
    .ack_req_o (ack_req_o)
  );

endmodule

// File: rtl/i2c_addr_filter_chk.sv
module i2c_addr_filter_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ten_bit_i,
  input logic              start_i,
  input logic              restart_i,
  input logic              stop_i,
  input logic              byte_vld_i,
  input logic [BYTE_W-1:0] byte_i,
  input logic              match_o,
  input logic              dir_rd_o,
  input logic              ack_req_o
);

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !match_o && !dir_rd_o);

  a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i || restart_i) |=> !match_o && !ack_req_o);

  a_r7_ack_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> $past(byte_vld_i) && !$past(stop_i));

  a_r2_match_rise_acked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) |-> ack_req_o);

  a_r2_dir_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_o) && $past(!ten_bit_i) |-> dir_rd_o == $past(byte_i[0]));

  a_r9_data_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    match_o && byte_vld_i && !start_i && !restart_i && !stop_i |=> !ack_req_o);

  a_r9_match_held: assert property (@(posedge clk) disable iff (!rst_n)
    match_o && !start_i && !restart_i && !stop_i |=> match_o && $stable(dir_rd_o));

endmodule

bind i2c_addr_filter i2c_addr_filter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ten_bit_i  (ten_bit_i),
  .start_i    (start_i),
  .restart_i  (restart_i),
  .stop_i     (stop_i),
  .byte_vld_i (byte_vld_i),
  .byte_i     (byte_i),
  .match_o    (match_o),
  .dir_rd_o   (dir_rd_o),
  .ack_req_o  (ack_req_o)
);

// File: tb/i2c_addr_filter_bench.sv
`timescale 1ns/1ps
module i2c_addr_filter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ten_bit_i = 1'b0;
  logic [6:0] own_hi_i = 7'h3A;
  logic       rw_cmp_i = 1'b0;
  logic [7:0] own_lo_i = 8'hC5;
  logic       start_i = 1'b0, restart_i = 1'b0, stop_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       match_o, dir_rd_o, ack_req_o;

  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  i2c_addr_filter u_i2c_addr_filter (
    .clk(clk), .rst_n(rst_n), .ten_bit_i(ten_bit_i), .own_hi_i(own_hi_i),
    .rw_cmp_i(rw_cmp_i), .own_lo_i(own_lo_i), .start_i(start_i),
    .restart_i(restart_i), .stop_i(stop_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .match_o(match_o), .dir_rd_o(dir_rd_o),
    .ack_req_o(ack_req_o)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // kind: 0 START, 1 repeated START, 2 STOP
  task automatic strobe(input int kind, input string tag);
    @(negedge clk);
    start_i = (kind == 0); restart_i = (kind == 1); stop_i = (kind == 2);
    @(negedge clk);
    start_i = 0; restart_i = 0; stop_i = 0;
    check({tag, " match cleared"}, match_o, 1'b0);
    check({tag, " no ack"}, ack_req_o, 1'b0);
  endtask

  task automatic send(input logic [7:0] b, input logic e_ack, input logic e_match,
                      input logic e_dir, input string tag);
    @(negedge clk);
    byte_i = b; byte_vld_i = 1;
    @(negedge clk);
    byte_vld_i = 0;
    check({tag, " ack"}, ack_req_o, e_ack);
    check({tag, " match"}, match_o, e_match);
    if (e_match) check({tag, " dir"}, dir_rd_o, e_dir);
  endtask

  task automatic t_reset;
    check("R11 reset match", match_o, 1'b0);
    check("R11 reset ack", ack_req_o, 1'b0);
    check("R11 reset dir", dir_rd_o, 1'b0);
    send({7'h3A, 1'b0}, 0, 0, 0, "R11 byte before START");
  endtask

  task automatic t_seven_bit;
    ten_bit_i = 0; rw_cmp_i = 0;
    strobe(0, "R10 start");
    send({7'h3A, 1'b0}, 1, 1, 0, "R1 R2 7-bit write");
    strobe(2, "R8 stop");
    strobe(0, "R10 start");
    send({7'h3A, 1'b1}, 1, 1, 1, "R2 7-bit read");
    strobe(2, "R8 stop");
    rw_cmp_i = 1;
    strobe(0, "R10 start");
    send({7'h3A, 1'b0}, 1, 1, 0, "R3 compare bit ignored");
    strobe(2, "R8 stop");
    rw_cmp_i = 0;
  endtask

  task automatic t_miss_then_deaf;
    ten_bit_i = 0;
    strobe(0, "R10 start");
    send({7'h3B, 1'b0}, 0, 0, 0, "R7 7-bit miss");
    send({7'h3A, 1'b0}, 0, 0, 0, "R7 ignored after miss");
    strobe(2, "R8 stop");
  endtask

  task automatic t_data_phase;
    ten_bit_i = 0;
    strobe(0, "R10 start");
    send({7'h3A, 1'b1}, 1, 1, 1, "R2 address");
    send(8'h5A, 0, 1, 1, "R9 data byte");
    send({7'h3A, 1'b0}, 0, 1, 1, "R9 data like address");
    strobe(2, "R8 stop");
  endtask

  task automatic t_ten_bit_write;
    ten_bit_i = 1; rw_cmp_i = 0; own_hi_i = 7'h79;
    strobe(0, "R10 start");
    send({7'h79, 1'b0}, 1, 0, 0, "R1 R4 10-bit first byte");
    send(8'hC5, 1, 1, 0, "R5 10-bit second byte");
    send(8'h11, 0, 1, 0, "R9 10-bit data");
    strobe(2, "R8 stop");
    strobe(0, "R10 start");
    send({7'h79, 1'b1}, 0, 0, 0, "R4 compare bit mismatch");
    send(8'hC5, 0, 0, 0, "R7 deaf after first miss");
    strobe(0, "R10 start");
    send({7'h79, 1'b0}, 1, 0, 0, "R4 first byte");
    send(8'hC4, 0, 0, 0, "R5 low byte miss");
    send(8'hC5, 0, 0, 0, "R7 deaf after low miss");
    strobe(2, "R8 stop");
  endtask

  task automatic t_ten_bit_read;
    ten_bit_i = 1; rw_cmp_i = 0;
    strobe(0, "R10 start");
    send({7'h79, 1'b0}, 1, 0, 0, "R6 write header");
    send(8'hC5, 1, 1, 0, "R6 write low");
    strobe(1, "R10 restart");
    send({7'h79, 1'b1}, 1, 1, 1, "R6 read turnaround");
    send(8'hC5, 0, 1, 1, "R9 after read");
    strobe(2, "R8 stop");
    strobe(1, "R6 restart after stop");
    send({7'h79, 1'b1}, 0, 0, 0, "R6 read refused after STOP");
    strobe(0, "R10 start");
    send({7'h79, 1'b1}, 0, 0, 0, "R6 read refused without header");
    strobe(2, "R8 stop");
  endtask

  task automatic t_same_cycle;
    ten_bit_i = 0; own_hi_i = 7'h3A;
    strobe(0, "R10 start");
    @(negedge clk);
    stop_i = 1; byte_i = {7'h3A, 1'b0}; byte_vld_i = 1;
    @(negedge clk);
    stop_i = 0; byte_vld_i = 0;
    check("R8 byte with STOP no ack", ack_req_o, 1'b0);
    check("R8 byte with STOP no match", match_o, 1'b0);
    send({7'h3A, 1'b0}, 0, 0, 0, "R8 idle after STOP");
    @(negedge clk);
    start_i = 1; byte_i = {7'h3A, 1'b0}; byte_vld_i = 1;
    @(negedge clk);
    start_i = 0; byte_vld_i = 0;
    check("R10 byte with START no ack", ack_req_o, 1'b0);
    send({7'h3A, 1'b0}, 1, 1, 0, "R10 armed after START");
    strobe(2, "R8 stop");
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_seven_bit();
    t_miss_then_deaf();
    t_data_phase();
    t_ten_bit_write();
    t_ten_bit_read();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule